// File: doc/BRIEF.md
# RF Output Gate Interlock

This block decides, for one RF channel, whether the fast signal switch and the slower power-amplifier stage are enabled. Software requests arrive as single-cycle strobes that carry a two-bit target selecting the switch, the amplifier, or both. Two asynchronous hardware pins act on the channel. One is a turn-on pin that enables both paths on a rising edge. The other is a turn-off interlock pin that works in one of two selectable behaviours, latching or level-following, or can be ignored altogether.

Both hardware pins pass through a two-flop synchroniser. They can then pass through an optional stability filter that accepts a new level only after it has held for a parameterised number of clocks. Both pins are treated as pulled high, so the synchronised and filtered levels reset to 1. A latched trip is shown on a status flag. It is released only by an explicit clear strobe, and only once the turn-off pin has gone inactive. Every input other than the two pins belongs to the block's clock domain. None of the block's interfaces carries a data stream, so every port is a plain control or status pin.

Top module: `rf_gate_ctrl`

## Requirements
- R1: While reset is held and on the first cycle after it, `sig_en_o`, `amp_en_o` and `tripped_o` are all 0.
- R2: A `sw_on_stb` sets the enables that `sw_target` selects (bit 0 = signal switch, bit 1 = amplifier). A `sw_off_stb` clears the selected enables. When both strobes arrive in the same cycle, off wins.
- R3: A rising level on `hw_on_pin` sets both enables. With the filter bypassed, the outputs change on the 4th rising clock edge after the pin changes (two synchroniser flops, one filter register, one state register). A pin that stays high does not enable the outputs again, and an edge has no effect on paths that are already on.
- R4: With `off_enable`=1 and `off_latch_mode`=1, a high level on the turn-off pin sets `tripped_o` and forces both enables to 0. This holds after the pin returns low, and software on requests are held off, until a clear is accepted.
- R5: A `trip_clear_stb` that arrives while the filtered turn-off level is still high leaves `tripped_o` at 1.
- R6: When a clear is accepted, `tripped_o` drops, and both enables stay 0 until a new on request arrives.
- R7: With `off_enable`=1 and `off_latch_mode`=0, `sig_en_o` follows the inverse of the filtered turn-off level (high gives 0, low gives 1) and overrides software on the switch path. `amp_en_o` is left to software and the turn-on pin. `tripped_o` stays 0.
- R8: With `off_enable`=0, the turn-off pin has no effect on any output and `tripped_o` is 0.
- R9: With `debounce_en`=1, a pin level is accepted only after it has differed from the accepted level for `DEBOUNCE_CYCLES` consecutive clocks. Shorter pulses are discarded. With the default of 4, the outputs change on the 7th edge after a clean pin change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_on_stb | input | 1 | Software turn-on strobe |
| sw_off_stb | input | 1 | Software turn-off strobe |
| sw_target | input | 2 | Strobe target: bit 0 switch, bit 1 amplifier |
| trip_clear_stb | input | 1 | Request to release a latched trip |
| off_enable | input | 1 | Turn-off pin is acted upon when 1 |
| off_latch_mode | input | 1 | 1 latching, 0 level-following |
| debounce_en | input | 1 | Enables the stability filter on both pins |
| hw_on_pin | input | 1 | Asynchronous turn-on pin |
| hw_off_pin | input | 1 | Asynchronous turn-off interlock pin, active high |
| sig_en_o | output | 1 | Fast signal switch enable |
| amp_en_o | output | 1 | Amplifier stage enable |
| tripped_o | output | 1 | Latched interlock has tripped |

## Verification
The assertions check several rules on every cycle. A trip keeps both enables low and persists without an accepted clear. A clear attempted while the turn-off level is high is refused. The trip flag is never set outside the latching mode. A software off strobe on the switch is obeyed unless the following mode owns that path. Only the bench scenarios can show the exact latency through the synchroniser and filter, that short glitches are discarded, and that a held-high turn-on pin does not re-enable the outputs. The same is true of the complete sequence of trip, refused clear, accepted clear and re-enable.

// File: rtl/rf_gate_pkg.sv
package rf_gate_pkg;
  localparam int TGT_SIG = 0;
  localparam int TGT_AMP = 1;
  localparam int PIN_ON  = 0;
  localparam int PIN_OFF = 1;
  localparam int NUM_PINS = 2;

  typedef struct packed {
    logic amp;
    logic sig;
  } gate_t;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= RST_VAL;
    else        chain[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[i] <= RST_VAL;
      else        chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/level_filter.sv
module level_filter #(
  parameter int   CYCLES  = 4,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic d,
  output logic q
);
  localparam int CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CYCLES - 1);

  logic [CNT_W-1:0] cnt;
  logic             level;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level <= RST_VAL;
      cnt   <= '0;
    end else if (!enable) begin
      level <= d;
      cnt   <= '0;
    end else if (d == level) begin
      cnt <= '0;
    end else if (cnt == CNT_LAST) begin
      level <= d;
      cnt   <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign q = level;
endmodule

// File: rtl/gate_core.sv
module gate_core
  import rf_gate_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sw_on_stb,
  input  logic       sw_off_stb,
  input  logic [1:0] sw_target,
  input  logic       trip_clear_stb,
  input  logic       off_enable,
  input  logic       off_latch_mode,
  input  logic       on_lvl,
  input  logic       off_lvl,
  output gate_t      gate,
  output logic       tripped
);
  gate_t gate_q, gate_d;
  logic  trip_q, trip_d;
  logic  on_prev;
  logic  on_edge, latch_act, follow_act;

  assign on_edge    = on_lvl & ~on_prev;
  assign latch_act  = off_enable & off_latch_mode;
  assign follow_act = off_enable & ~off_latch_mode;

  always_comb begin
    gate_d = gate_q;
    if (on_edge) begin
      gate_d.sig = 1'b1;
      gate_d.amp = 1'b1;
    end
    if (sw_on_stb) begin
      if (sw_target[TGT_SIG]) gate_d.sig = 1'b1;
      if (sw_target[TGT_AMP]) gate_d.amp = 1'b1;
    end
    if (sw_off_stb) begin
      if (sw_target[TGT_SIG]) gate_d.sig = 1'b0;
      if (sw_target[TGT_AMP]) gate_d.amp = 1'b0;
    end

    trip_d = 1'b0;
    if (latch_act) begin
      if (off_lvl)             trip_d = 1'b1;
      else if (trip_clear_stb) trip_d = 1'b0;
      else                     trip_d = trip_q;
    end

    if (follow_act) gate_d.sig = ~off_lvl;
    if (trip_d) begin
      gate_d.sig = 1'b0;
      gate_d.amp = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q  <= '0;
      trip_q  <= 1'b0;
      on_prev <= 1'b1;
    end else begin
      gate_q  <= gate_d;
      trip_q  <= trip_d;
      on_prev <= on_lvl;
    end
  end

  assign gate    = gate_q;
  assign tripped = trip_q;
endmodule

// File: rtl/rf_gate_ctrl.sv
module rf_gate_ctrl
  import rf_gate_pkg::*;
#(
  parameter int SYNC_STAGES     = 2,
  parameter int DEBOUNCE_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sw_on_stb,
  input  logic       sw_off_stb,
  input  logic [1:0] sw_target,
  input  logic       trip_clear_stb,
  input  logic       off_enable,
  input  logic       off_latch_mode,
  input  logic       debounce_en,
  input  logic       hw_on_pin,
  input  logic       hw_off_pin,
  output logic       sig_en_o,
  output logic       amp_en_o,
  output logic       tripped_o
);
  logic [NUM_PINS-1:0] pin_raw, pin_sync_q, pin_filt;
  gate_t gate;

  assign pin_raw[PIN_ON]  = hw_on_pin;
  assign pin_raw[PIN_OFF] = hw_off_pin;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pin_raw[p]), .q(pin_sync_q[p])
    );
    level_filter #(.CYCLES(DEBOUNCE_CYCLES), .RST_VAL(1'b1)) u_filt (
      .clk(clk), .rst_n(rst_n), .enable(debounce_en),
      .d(pin_sync_q[p]), .q(pin_filt[p])
    );
  end

  gate_core u_core (
    .clk(clk), .rst_n(rst_n),
    .sw_on_stb(sw_on_stb), .sw_off_stb(sw_off_stb), .sw_target(sw_target),
    .trip_clear_stb(trip_clear_stb),
    .off_enable(off_enable), .off_latch_mode(off_latch_mode),
    .on_lvl(pin_filt[PIN_ON]), .off_lvl(pin_filt[PIN_OFF]),
    .gate(gate), .tripped(tripped_o)
  );

  assign sig_en_o = gate.sig;
  assign amp_en_o = gate.amp;
endmodule

// File: rtl/rf_gate_ctrl_chk.sv
module rf_gate_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sw_off_stb,
  input logic [1:0] sw_target,
  input logic       trip_clear_stb,
  input logic       off_enable,
  input logic       off_latch_mode,
  input logic       off_filt,
  input logic       sig_en_o,
  input logic       amp_en_o,
  input logic       tripped_o
);
  AST_TRIP_FORCES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    tripped_o |-> (!sig_en_o && !amp_en_o)); // R4

  AST_TRIP_PERSISTS: assert property (@(posedge clk) disable iff (!rst_n)
    (tripped_o && !trip_clear_stb && off_enable && off_latch_mode) |=> tripped_o); // R4

  AST_CLEAR_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    (off_enable && off_latch_mode && off_filt) |=> tripped_o); // R5

  AST_NO_TRIP_UNLATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    !(off_enable && off_latch_mode) |=> !tripped_o); // R8

  AST_SW_OFF_OBEYED: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_off_stb && sw_target[0] && !(off_enable && !off_latch_mode)) |=> !sig_en_o); // R2
endmodule

bind rf_gate_ctrl rf_gate_ctrl_chk i_chk (
  .clk(clk), .rst_n(rst_n), .sw_off_stb(sw_off_stb), .sw_target(sw_target),
  .trip_clear_stb(trip_clear_stb), .off_enable(off_enable),
  .off_latch_mode(off_latch_mode), .off_filt(pin_filt[1]),
  .sig_en_o(sig_en_o), .amp_en_o(amp_en_o), .tripped_o(tripped_o)
);

// File: tb/test_rf_gate_ctrl.sv
`timescale 1ns/1ps
module test_rf_gate_ctrl;
  localparam int DEB = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sw_on_stb = 0, sw_off_stb = 0, trip_clear_stb = 0;
  logic [1:0] sw_target = 2'b00;
  logic off_enable = 0, off_latch_mode = 0, debounce_en = 0;
  logic hw_on_pin = 0, hw_off_pin = 0;
  logic sig_en_o, amp_en_o, tripped_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  rf_gate_ctrl #(.SYNC_STAGES(2), .DEBOUNCE_CYCLES(DEB)) i_rf_gate_ctrl (
    .clk(clk), .rst_n(rst_n), .sw_on_stb(sw_on_stb), .sw_off_stb(sw_off_stb),
    .sw_target(sw_target), .trip_clear_stb(trip_clear_stb),
    .off_enable(off_enable), .off_latch_mode(off_latch_mode),
    .debounce_en(debounce_en), .hw_on_pin(hw_on_pin), .hw_off_pin(hw_off_pin),
    .sig_en_o(sig_en_o), .amp_en_o(amp_en_o), .tripped_o(tripped_o)
  );

  // behavioural reference: pin delay queues, integer stability counters, mode rules
  bit pq_on[$];
  bit pq_off[$];
  bit acc[2];
  int stab[2];
  bit m_onp, m_sig, m_amp, m_trip;

  always @(posedge clk) begin
    if (!rst_n) begin
      pq_on = '{1'b1, 1'b1};
      pq_off = '{1'b1, 1'b1};
      acc[0] = 1; acc[1] = 1; stab[0] = 0; stab[1] = 0;
      m_onp = 1; m_sig = 0; m_amp = 0; m_trip = 0;
    end else begin
      bit sync_lvl[2];
      bit latch, follow;
      // decision on currently accepted levels
      latch  = off_enable && off_latch_mode;
      follow = off_enable && !off_latch_mode;
      if (acc[0] && !m_onp) begin m_sig = 1; m_amp = 1; end
      m_onp = acc[0];
      if (sw_on_stb) begin
        if (sw_target[0]) m_sig = 1;
        if (sw_target[1]) m_amp = 1;
      end
      if (sw_off_stb) begin
        if (sw_target[0]) m_sig = 0;
        if (sw_target[1]) m_amp = 0;
      end
      if (!latch) m_trip = 0;
      else if (acc[1]) m_trip = 1;
      else if (trip_clear_stb) m_trip = 0;
      if (follow) m_sig = !acc[1];
      if (m_trip) begin m_sig = 0; m_amp = 0; end
      // acceptance of synchronised levels
      sync_lvl[0] = pq_on[0];
      sync_lvl[1] = pq_off[0];
      for (int i = 0; i < 2; i++) begin
        if (!debounce_en) begin acc[i] = sync_lvl[i]; stab[i] = 0; end
        else if (sync_lvl[i] == acc[i]) stab[i] = 0;
        else begin
          stab[i]++;
          if (stab[i] >= DEB) begin acc[i] = sync_lvl[i]; stab[i] = 0; end
        end
      end
      void'(pq_on.pop_front());
      void'(pq_off.pop_front());
      pq_on.push_back(hw_on_pin);
      pq_off.push_back(hw_off_pin);
    end
  end

  // compare with the reference on every falling edge once out of reset
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      n_cmp++;
      if ({sig_en_o, amp_en_o, tripped_o} !== {m_sig, m_amp, m_trip}) begin
        n_bad++;
        $display("FAIL model t=%0t: actual sig/amp/trip=%b%b%b expected=%b%b%b",
                 $time, sig_en_o, amp_en_o, tripped_o, m_sig, m_amp, m_trip);
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, bit es, bit ea, bit et);
    n_cmp++;
    if ({sig_en_o, amp_en_o, tripped_o} !== {es, ea, et}) begin
      n_bad++;
      $display("FAIL %s t=%0t: actual sig/amp/trip=%b%b%b expected=%b%b%b",
               req, $time, sig_en_o, amp_en_o, tripped_o, es, ea, et);
    end
  endtask

  task automatic sw(bit on, bit off, logic [1:0] tgt);
    sw_on_stb = on; sw_off_stb = off; sw_target = tgt;
    tick(1);
    sw_on_stb = 0; sw_off_stb = 0; sw_target = 2'b00;
  endtask

  task automatic clear_trip();
    trip_clear_stb = 1;
    tick(1);
    trip_clear_stb = 0;
  endtask

  task automatic finish_run();
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    tick(1);
    chk("R1", 0, 0, 0);
    tick(2);
    rst_n = 1;
    tick(1);
    chk("R1", 0, 0, 0);
    tick(4);

    // R2 software strobes and targets
    sw(1, 0, 2'b01); tick(1); chk("R2", 1, 0, 0);
    sw(1, 0, 2'b10); tick(1); chk("R2", 1, 1, 0);
    sw(0, 1, 2'b01); tick(1); chk("R2", 0, 1, 0);
    sw(1, 1, 2'b11); tick(1); chk("R2", 0, 0, 0);

    // R3 turn-on pin latency and held level
    hw_on_pin = 1;
    tick(3); chk("R3", 0, 0, 0);
    tick(1); chk("R3", 1, 1, 0);
    sw(0, 1, 2'b01); tick(6); chk("R3", 0, 1, 0);
    hw_on_pin = 0; tick(6); chk("R3", 0, 1, 0);
    hw_on_pin = 1; tick(6); chk("R3", 1, 1, 0);
    hw_on_pin = 0; tick(6);

    // R8 turn-off pin ignored when disabled
    hw_off_pin = 1; tick(8); chk("R8", 1, 1, 0);

    // R4 latching trip
    off_latch_mode = 1; off_enable = 1;
    tick(2); chk("R4", 0, 0, 1);
    hw_off_pin = 0; tick(6); chk("R4", 0, 0, 1);
    sw(1, 0, 2'b11); tick(1); chk("R4", 0, 0, 1);

    // R5 clear refused while pin high
    hw_off_pin = 1; tick(6);
    clear_trip(); tick(1); chk("R5", 0, 0, 1);

    // R6 accepted clear, outputs stay off until re-enabled
    hw_off_pin = 0; tick(6); chk("R6", 0, 0, 1);
    clear_trip(); chk("R6", 0, 0, 0);
    tick(4); chk("R6", 0, 0, 0);
    sw(1, 0, 2'b11); tick(1); chk("R6", 1, 1, 0);

    // R7 level-following mode
    off_latch_mode = 0; tick(2); chk("R7", 1, 1, 0);
    hw_off_pin = 1; tick(6); chk("R7", 0, 1, 0);
    sw(1, 0, 2'b01); tick(1); chk("R7", 0, 1, 0);
    hw_off_pin = 0; tick(6); chk("R7", 1, 1, 0);
    sw(0, 1, 2'b01); tick(1); chk("R7", 1, 1, 0);

    // R9 stability filter
    debounce_en = 1;
    hw_off_pin = 1; tick(12); chk("R9", 0, 1, 0);
    hw_off_pin = 0; tick(3); hw_off_pin = 1;
    tick(12); chk("R9", 0, 1, 0);
    hw_off_pin = 0;
    tick(6); chk("R9", 0, 1, 0);
    tick(1); chk("R9", 1, 1, 0);
    hw_on_pin = 1; tick(2); hw_on_pin = 0;
    sw(0, 1, 2'b10); tick(12); chk("R9", 1, 0, 0);

    tick(4);
    finish_run();
  end
endmodule